// File: doc/BRIEF.md
# Wrapping Burst Address Generator

This block walks through the addresses of one bus burst. A load strobe captures a start address, a transfer-size code and a burst code. From the next cycle the block presents the first beat address. Each advance strobe then moves it to the following beat. Incrementing bursts step upward by the transfer size with no limit. Wrapping bursts stay inside an aligned window whose byte size is the beat count times the transfer size. Only the address bits below that window roll over. A carry out of the window is dropped, so the bits above it never change during the burst.

The block also keeps a count of the beats still to be presented, including the current one, and raises a flag while the final beat address is shown. An advance on the final beat closes the burst. Handshaking, wait states and data movement belong to the surrounding bus logic. That logic only has to pulse the advance strobe when a beat completes. Start addresses are expected to be aligned to the transfer size.

Top module: `burst_addr_seq`

## Requirements
- R1: A synchronous active-high reset clears the address output and the beat count to zero and drives the last-beat flag low.
- R2: A load strobe captures the start address and the burst. In the following cycle the address output equals the start address and the beat count equals the burst length. The length is selected by burst code bits [1:0]: 0 gives 1 beat, 1 gives 4, 2 gives 8 and 3 gives 16.
- R3: The transfer size in bytes is 2 to the power of the size code: code 0 is 1 byte, 1 is 2 bytes, 2 is 4 bytes and 3 is 8 bytes. When burst code bit [2] is 0 (incrementing), each accepted advance adds that byte count to the address, with carries allowed into any bit.
- R4: When burst code bit [2] is 1 (wrapping), the window is beats times bytes, aligned to its own size. Each accepted advance adds the byte count to the bits below the window and drops the carry, leaving the bits above unchanged. Examples: a 4-beat word burst from 0x4 gives 0x4, 0x8, 0xC, 0x0. From 0x34 it gives 0x34, 0x38, 0x3C, 0x30. A 4-beat halfword burst from 0x4 gives 0x4, 0x6, 0x0, 0x2.
- R5: Each advance accepted while the beat count is above one lowers the count by exactly one. The last-beat flag is high exactly when the beat count is one.
- R6: An advance while the beat count is one ends the burst: the count goes to zero, the flag goes low and the address holds. An advance while the count is zero, or any cycle with no load and no advance, leaves the address and count unchanged.
- R7: When load and advance are strobed in the same cycle, the load wins and the advance has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| load_i | input | 1 | Start a new burst |
| start_addr_i | input | ADDR_W | First beat address, sampled on load |
| size_i | input | SIZE_W | Transfer-size code, bytes = 2**code |
| burst_i | input | 3 | Bit 2: wrap enable; bits 1:0: length select |
| advance_i | input | 1 | Move to the next beat |
| addr_o | output | ADDR_W | Address of the beat now presented |
| beats_left_o | output | 5 | Beats remaining including the current one |
| last_o | output | 1 | High while the final beat address is presented |

## Verification
The three stated sequences (word wrap from 0x4 and from 0x34, halfword wrap from 0x4) are checked against fixed values. Together they separate a window built from the beat count alone from one built from beats times size. They also show whether the carry out of the window is dropped or leaks into the upper bits. An incrementing burst across a 0x100 boundary and 8- and 16-beat wraps of byte and doubleword size show that the wrap applies only when selected and scales with both fields. A long run of pseudo-random aligned bursts with irregular advance gaps, back-to-back loads, load with advance and advances past the end is then compared cycle by cycle against a behavioural model. That run covers counter, flag and hold behaviour.

// File: rtl/bas_pkg.sv
package bas_pkg;

  localparam int unsigned BEAT_MAX    = 16;
  localparam int unsigned CNT_W       = $clog2(BEAT_MAX + 1);
  localparam int unsigned LEN_LOG_MAX = $clog2(BEAT_MAX);

  typedef enum logic [1:0] {
    LEN_1  = 2'd0,
    LEN_4  = 2'd1,
    LEN_8  = 2'd2,
    LEN_16 = 2'd3
  } len_sel_e;

  typedef struct packed {
    logic     wrap;
    len_sel_e len;
  } burst_code_t;

  function automatic int unsigned len_log_of(len_sel_e sel);
    case (sel)
      LEN_4:   return 2;
      LEN_8:   return 3;
      LEN_16:  return 4;
      default: return 0;
    endcase
  endfunction

  function automatic int unsigned beats_of(len_sel_e sel);
    return 32'd1 << len_log_of(sel);
  endfunction

endpackage

// File: rtl/bas_burst_decode.sv
module bas_burst_decode
  import bas_pkg::*;
#(
  parameter int SIZE_W = 2,
  parameter int WLOG_W = 3
) (
  input  logic [SIZE_W-1:0] size_i,
  input  logic [2:0]        burst_i,
  output logic [CNT_W-1:0]  beats_o,
  output logic              wrap_o,
  output logic [WLOG_W-1:0] wlog_o
);

  burst_code_t code;

  always_comb begin
    code    = burst_code_t'(burst_i);
    wrap_o  = code.wrap;
    beats_o = CNT_W'(beats_of(code.len));
    // window is beats * bytes, both powers of two: add the exponents
    wlog_o  = WLOG_W'(size_i) + WLOG_W'(len_log_of(code.len));
  end

endmodule

// File: rtl/bas_addr_step.sv
module bas_addr_step #(
  parameter int ADDR_W = 32,
  parameter int SIZE_W = 2,
  parameter int WLOG_W = 3
) (
  input  logic [ADDR_W-1:0] cur_i,
  input  logic [SIZE_W-1:0] size_i,
  input  logic              wrap_i,
  input  logic [WLOG_W-1:0] wlog_i,
  output logic [ADDR_W-1:0] bytes_o,
  output logic [ADDR_W-1:0] low_mask_o,
  output logic [ADDR_W-1:0] nxt_o
);

  function automatic logic [ADDR_W-1:0] bytes_of(logic [SIZE_W-1:0] sz);
    return ADDR_W'(1) << sz;
  endfunction

  function automatic logic [ADDR_W-1:0] mask_of(logic [WLOG_W-1:0] wl);
    return ~({ADDR_W{1'b1}} << wl);
  endfunction

  function automatic logic [ADDR_W-1:0] advance_addr(
    logic [ADDR_W-1:0] cur,
    logic [ADDR_W-1:0] step,
    logic [ADDR_W-1:0] lmask,
    logic              wrap
  );
    logic [ADDR_W-1:0] sum;
    sum = cur + step;
    if (wrap) return (cur & ~lmask) | (sum & lmask);
    return sum;
  endfunction

  always_comb begin
    bytes_o    = bytes_of(size_i);
    low_mask_o = mask_of(wlog_i);
    nxt_o      = advance_addr(cur_i, bytes_o, low_mask_o, wrap_i);
  end

endmodule

// File: rtl/bas_beat_ctr.sv
module bas_beat_ctr
  import bas_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_beats_i,
  input  logic             adv_i,
  output logic [CNT_W-1:0] count_o,
  output logic             last_o,
  output logic             step_o
);

  logic [CNT_W-1:0] count_q;
  logic             last_q;
  logic             adv_take;
  logic             finish;

  assign adv_take = adv_i && !load_i && (count_q != '0);
  assign step_o   = adv_take && (count_q > CNT_W'(1));
  assign finish   = adv_take && (count_q == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      count_q <= '0;
      last_q  <= 1'b0;
    end else if (load_i) begin
      count_q <= load_beats_i;
      last_q  <= (load_beats_i == CNT_W'(1));
    end else if (step_o) begin
      count_q <= count_q - CNT_W'(1);
      last_q  <= (count_q == CNT_W'(2));
    end else if (finish) begin
      count_q <= '0;
      last_q  <= 1'b0;
    end
  end

  assign count_o = count_q;
  assign last_o  = last_q;

  p_last_flag_r5: assert property (@(posedge clk) disable iff (rst)
    last_q == (count_q == CNT_W'(1)))
    else $error("last flag disagrees with beat count");

  p_count_dec_r5: assert property (@(posedge clk) disable iff (rst)
    step_o |=> count_q == $past(count_q) - CNT_W'(1))
    else $error("beat count did not drop by one");

  p_finish_r6: assert property (@(posedge clk) disable iff (rst)
    finish |=> (count_q == '0) && !last_q)
    else $error("burst did not close on final advance");

  p_load_wins_r7: assert property (@(posedge clk) disable iff (rst)
    (load_i && adv_i) |=> count_q == $past(load_beats_i))
    else $error("advance overrode a load");

endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import bas_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int SIZE_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] start_addr_i,
  input  logic [SIZE_W-1:0] size_i,
  input  logic [2:0]        burst_i,
  input  logic              advance_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [CNT_W-1:0]  beats_left_o,
  output logic              last_o
);

  localparam int WLOG_W = $clog2((1 << SIZE_W) + LEN_LOG_MAX);

  logic [CNT_W-1:0]  dec_beats;
  logic              dec_wrap;
  logic [WLOG_W-1:0] dec_wlog;

  logic [SIZE_W-1:0] size_q;
  logic              wrap_q;
  logic [WLOG_W-1:0] wlog_q;
  logic [ADDR_W-1:0] addr_q;

  logic [ADDR_W-1:0] step_bytes;
  logic [ADDR_W-1:0] low_mask;
  logic [ADDR_W-1:0] addr_nxt;
  logic              step;

  bas_burst_decode #(.SIZE_W(SIZE_W), .WLOG_W(WLOG_W)) u_decode (
    .size_i  (size_i),
    .burst_i (burst_i),
    .beats_o (dec_beats),
    .wrap_o  (dec_wrap),
    .wlog_o  (dec_wlog)
  );

  bas_addr_step #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .WLOG_W(WLOG_W)) u_step (
    .cur_i      (addr_q),
    .size_i     (size_q),
    .wrap_i     (wrap_q),
    .wlog_i     (wlog_q),
    .bytes_o    (step_bytes),
    .low_mask_o (low_mask),
    .nxt_o      (addr_nxt)
  );

  bas_beat_ctr u_ctr (
    .clk          (clk),
    .rst          (rst),
    .load_i       (load_i),
    .load_beats_i (dec_beats),
    .adv_i        (advance_i),
    .count_o      (beats_left_o),
    .last_o       (last_o),
    .step_o       (step)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      size_q <= '0;
      wrap_q <= 1'b0;
      wlog_q <= '0;
    end else if (load_i) begin
      size_q <= size_i;
      wrap_q <= dec_wrap;
      wlog_q <= dec_wlog;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         addr_q <= '0;
    else if (load_i) addr_q <= start_addr_i;
    else if (step)   addr_q <= addr_nxt;
  end

  assign addr_o = addr_q;

  p_reset_r1: assert property (@(posedge clk)
    rst |=> (addr_q == '0) && (beats_left_o == '0) && !last_o)
    else $error("reset state wrong");

  p_load_r2: assert property (@(posedge clk) disable iff (rst)
    load_i |=> (addr_q == $past(start_addr_i)) && (beats_left_o == $past(dec_beats)))
    else $error("load not captured");

  p_incr_step_r3: assert property (@(posedge clk) disable iff (rst)
    (step && !wrap_q) |=> addr_q == $past(addr_q) + $past(step_bytes))
    else $error("incrementing step wrong");

  p_wrap_upper_r4: assert property (@(posedge clk) disable iff (rst)
    (step && wrap_q) |=> ((addr_q ^ $past(addr_q)) & ~$past(low_mask)) == '0)
    else $error("wrap disturbed bits above the window");

  p_wrap_low_r4: assert property (@(posedge clk) disable iff (rst)
    (step && wrap_q) |=>
      (addr_q & $past(low_mask)) == (($past(addr_q) + $past(step_bytes)) & $past(low_mask)))
    else $error("wrap offset wrong");

  p_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (!load_i && !step) |=> $stable(addr_q))
    else $error("address moved without an accepted advance");

endmodule

// File: tb/test_burst_addr_seq.sv
module test_burst_addr_seq;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          load = 1'b0;
  logic [AW-1:0] start = '0;
  logic [1:0]    size = '0;
  logic [2:0]    burst = '0;
  logic          adv = 1'b0;
  logic [AW-1:0] addr;
  logic [4:0]    beats_left;
  logic          last;

  int checks = 0;
  int fails = 0;
  bit done = 0;
  string cur_req = "R1";

  bit [31:0] m_addr = 0;
  int        m_cnt = 0;
  int        m_bytes = 1;
  bit        m_wrap = 0;
  int        m_win = 1;

  always #(CLK_PERIOD/2) clk = ~clk;

  burst_addr_seq #(.ADDR_W(AW), .SIZE_W(2)) i_burst_addr_seq (
    .clk(clk), .rst(rst), .load_i(load), .start_addr_i(start), .size_i(size),
    .burst_i(burst), .advance_i(adv), .addr_o(addr), .beats_left_o(beats_left),
    .last_o(last)
  );

  function automatic int len_of(bit [1:0] sel);
    case (sel)
      2'd0: return 1;
      2'd1: return 4;
      2'd2: return 8;
      default: return 16;
    endcase
  endfunction

  task automatic model_edge();
    if (rst) begin
      m_addr = 0; m_cnt = 0;
    end else if (load) begin
      m_addr  = start;
      m_cnt   = len_of(burst[1:0]);
      m_bytes = 1 << size;
      m_wrap  = burst[2];
      m_win   = m_cnt * m_bytes;
    end else if (adv && m_cnt > 0) begin
      if (m_cnt > 1) begin
        if (m_wrap) begin
          bit [31:0] base;
          base   = m_addr - (m_addr % m_win);
          m_addr = base + ((m_addr - base + m_bytes) % m_win);
        end else begin
          m_addr = m_addr + m_bytes;
        end
      end
      m_cnt--;
    end
  endtask

  task automatic compare_model();
    checks++;
    if (addr !== m_addr || beats_left !== 5'(m_cnt) || last !== (m_cnt == 1)) begin
      fails++;
      $display("FAIL %s addr=%h cnt=%0d last=%b expected addr=%h cnt=%0d last=%b",
               cur_req, addr, beats_left, last, m_addr, m_cnt, (m_cnt == 1));
    end
  endtask

  task automatic step(input bit ld, input bit [31:0] st, input bit [1:0] sz,
                      input bit [2:0] bt, input bit a);
    load = ld; start = st; size = sz; burst = bt; adv = a;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare_model();
  endtask

  task automatic expect_addr(input string tag, input bit [31:0] exp);
    checks++;
    if (addr !== exp) begin
      fails++;
      $display("FAIL %s fixed sequence addr=%h expected %h", tag, addr, exp);
    end
  endtask

  task automatic seq4(input string tag, input bit [31:0] st, input bit [1:0] sz,
                      input bit [2:0] bt, input bit [31:0] e0, input bit [31:0] e1,
                      input bit [31:0] e2, input bit [31:0] e3);
    cur_req = tag;
    step(1, st, sz, bt, 0);  expect_addr(tag, e0);
    step(0, 0, 0, 0, 1);     expect_addr(tag, e1);
    step(0, 0, 0, 0, 1);     expect_addr(tag, e2);
    step(0, 0, 0, 0, 1);     expect_addr(tag, e3);
  endtask

  task automatic run_burst(input bit [31:0] st, input bit [1:0] sz, input bit [2:0] bt,
                           input int gap_pct);
    int n;
    n = len_of(bt[1:0]);
    step(1, st, sz, bt, 0);
    for (int k = 0; k < n; k++) begin
      while (($urandom % 100) < gap_pct) step(0, 0, 0, 0, 0);
      step(0, 0, 0, 0, 1);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    @(negedge clk);
    cur_req = "R1";
    step(0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0);
    rst = 1'b0;
    step(0, 0, 0, 0, 0);

    // R4 fixed sequences: word, word, halfword
    seq4("R4", 32'h4,  2'd2, 3'b101, 32'h4,  32'h8,  32'hC,  32'h0);
    seq4("R4", 32'h34, 2'd2, 3'b101, 32'h34, 32'h38, 32'h3C, 32'h30);
    seq4("R4", 32'h4,  2'd1, 3'b101, 32'h4,  32'h6,  32'h0,  32'h2);
    // R3 incrementing across 0x100
    seq4("R3", 32'hF8, 2'd2, 3'b001, 32'hF8, 32'hFC, 32'h100, 32'h104);

    // R2 / R5 longer wraps, counter and flag compared by model every cycle
    cur_req = "R5";
    run_burst(32'h0000_101C, 2'd2, 3'b110, 0);
    run_burst(32'hABCD_002F, 2'd0, 3'b111, 0);
    run_burst(32'h0000_0318, 2'd3, 3'b101, 0);
    cur_req = "R2";
    step(1, 32'h0000_0040, 2'd2, 3'b000, 0);

    // R6 advance on single last beat, then idle advances
    cur_req = "R6";
    step(0, 0, 0, 0, 1);
    step(0, 0, 0, 0, 1);
    step(0, 0, 0, 0, 0);

    // R7 load together with advance mid-burst
    cur_req = "R7";
    step(1, 32'h200, 2'd1, 3'b110, 0);
    step(0, 0, 0, 0, 1);
    step(1, 32'h500, 2'd2, 3'b101, 1);
    step(0, 0, 0, 0, 1);

    // random aligned bursts with gaps and overlapping loads
    for (int b = 0; b < 200; b++) begin
      bit [1:0]  sz;
      bit [2:0]  bt;
      bit [31:0] st;
      sz = 2'($urandom % 4);
      bt = 3'($urandom % 8);
      st = $urandom & ~((32'd1 << sz) - 1);
      cur_req = bt[2] ? "R4" : "R3";
      if (b % 7 == 3) begin
        cur_req = "R7";
        step(1, st, sz, bt, 1);
        step(0, 0, 0, 0, 1);
      end
      run_burst(st, sz, bt, 30);
      cur_req = "R6";
      step(0, 0, 0, 0, 1);
    end

    cur_req = "R1";
    rst = 1'b1;
    step(0, 0, 0, 0, 1);
    rst = 1'b0;
    step(0, 0, 0, 0, 0);
    finish_run();
  end

endmodule